// File: doc/BRIEF.md
# 64-bit Bus Target Write Sequencer

This block sequences the target side of memory write transactions on a 64-bit PCI bus, for both single-cycle writes and bursts. It watches the frame, 64-bit request and initiator-ready strobes and the multiplexed address/data and command/byte-enable lines. It claims a transaction when an external base-address decoder reports a hit, and it drives the target control lines with their own output-enable controls. Each completed bus data phase is handed to a local-side consumer one clock later.

On the local side the block presents the latched address, command and hit vector. It then presents each registered quadword with its byte enables, and marks it with an acknowledge strobe. A transfer strobe shows the clocks in which the local side actually took the data. A frame strobe toward the local side brackets the whole transaction, including the pipeline drain. The local consumer paces the first bus data phase through its ready input. Parity, reads, configuration cycles and target-initiated termination are not handled here.

Top module: `pciwr_target`

## Requirements
- R1: While reset is active and after its release with an idle bus, all output enables are low, devselN, trdyN, ack64N, stopN, localAckN, localXferN and localFrameN are high.
- R2: When pciFrameN is low in an idle clock, pciAd[31:0] and pciCbe[3:0] are latched as address and command, and a low pciReq64N marks a 64-bit request. These appear on localAddr and localCmd no later than the claim clock, and localBarSel shows the hit vector that was sampled in the decode clock.
- R3: The hit vector is sampled in the clock after the address phase (decode clock). If any bit is set, ctlOe and adOe go high in the next clock (claim clock) and localFrameN goes low in that same clock.
- R4: devselN goes low one clock after the claim clock and stays low until the final data phase completes. ack64N goes low together with it only when the request was 64-bit, and stopN is always high while driven.
- R5: parOe rises exactly one clock after ctlOe rises and falls with it.
- R6: trdyN stays high in the first data phase until localRdyN has been sampled low in the claim clock or later, so a late local side delays trdyN by as many clocks.
- R7: A bus data phase with pciIrdyN and trdyN both low is registered. In the next clock its quadword and byte enables are on localData and localBe with localAckN low. A clock without a completed phase (for example an initiator wait) gives localAckN high in the next clock.
- R8: localXferN is low in a clock only when localAckN is low and localRdyN was low in the previous clock.
- R9: A data phase completing with pciFrameN high is the final one. In the next clock devselN, trdyN and ack64N are driven high with ctlOe still high, and in the clock after that ctlOe, adOe and parOe are low.
- R10: localFrameN returns high one clock after the clock in which the output enables turned off.
- R11: A transaction with no hit enables no driver and leaves localFrameN and localAckN high. The block waits until pciFrameN and pciIrdyN are both high before it accepts a new address phase.
- R12: After the first data phase of a burst, trdyN stays low for each further data phase, so initiator wait states alone pace the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| pciFrameN | input | 1 | Frame strobe from the initiator, active low |
| pciReq64N | input | 1 | 64-bit request strobe, active low |
| pciIrdyN | input | 1 | Initiator ready, active low |
| pciAd | input | 64 | Multiplexed address/data lines |
| pciCbe | input | 8 | Command/byte-enable lines |
| barHit | input | 6 | Base-address decode hit vector, one bit per window |
| devselN | output | 1 | Device select, active low |
| ack64N | output | 1 | 64-bit acknowledge, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Stop, held high |
| ctlOe | output | 1 | Output enable for devselN, ack64N, trdyN, stopN |
| adOe | output | 1 | Output enable for the address/data lines |
| parOe | output | 1 | Output enable for the parity lines |
| localAddr | output | 32 | Latched transaction address |
| localCmd | output | 4 | Latched bus command |
| localReq64 | output | 1 | Latched 64-bit request flag |
| localBarSel | output | 6 | Hit vector of the claimed transaction |
| localFrameN | output | 1 | Transaction in progress toward the local side, active low |
| localRdyN | input | 1 | Local side ready to take data, active low |
| localAckN | output | 1 | Valid data on localData/localBe, active low |
| localXferN | output | 1 | Local transfer taking place, active low |
| localData | output | 64 | Registered write quadword |
| localBe | output | 8 | Registered byte enables |

## Verification
A zero-wait burst with one initiator wait state and one local wait state shows apart the bus-side pause, which drops the acknowledge, from the local pause, which drops only the transfer strobe. A 32-bit single write with a late local ready shows whether trdyN is held back by the right number of clocks and whether ack64N follows the request width. A missed decode, followed by a stray frame-low clock during its data phases, shows whether the block truly waits for an idle bus before it decodes again. A following hit transaction shows it still claims normally.

// File: rtl/pciwr_pkg.sv
package pciwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM,
    ST_DATA,
    ST_TURN,
    ST_SKIP
  } wrState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchAddr;  // address phase seen in idle
    logic claim;      // decode hit, record hit vector
    logic capture;    // bus data phase completed
  } dpStrobe_t;

endpackage

// File: rtl/pciwr_dpath.sv
module pciwr_dpath
  import pciwr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_BARS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [DATA_W-1:0]     pciAd,
  input  logic [DATA_W/8-1:0]   pciCbe,
  input  logic                  pciReq64N,
  input  logic [NUM_BARS-1:0]   barHit,
  output logic                  anyHit,
  output logic [DATA_W/2-1:0]   localAddr,
  output logic [DATA_W/16-1:0]  localCmd,
  output logic                  localReq64,
  output logic [NUM_BARS-1:0]   localBarSel,
  output logic [DATA_W-1:0]     localData,
  output logic [DATA_W/8-1:0]   localBe
);

  localparam int ADDR_W = DATA_W / 2;
  localparam int BE_W   = DATA_W / 8;
  localparam int CMD_W  = BE_W / 2;
  localparam int LANE_W = 32;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int LBE_W  = LANE_W / 8;

  logic [ADDR_W-1:0]   addrReg;
  logic [CMD_W-1:0]    cmdReg;
  logic                req64Reg;
  logic [NUM_BARS-1:0] barReg;

  assign anyHit = |barHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      cmdReg   <= '0;
      req64Reg <= 1'b0;
    end else if (strobe.latchAddr) begin
      addrReg  <= pciAd[ADDR_W-1:0];
      cmdReg   <= pciCbe[CMD_W-1:0];
      req64Reg <= ~pciReq64N;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      barReg <= '0;
    end else if (strobe.claim) begin
      barReg <= barHit;
    end
  end

  // one capture register per 32-bit lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneData;
    logic [LBE_W-1:0]  laneBe;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneData <= '0;
        laneBe   <= '0;
      end else if (strobe.capture) begin
        laneData <= pciAd[g*LANE_W +: LANE_W];
        laneBe   <= pciCbe[g*LBE_W +: LBE_W];
      end
    end

    assign localData[g*LANE_W +: LANE_W] = laneData;
    assign localBe[g*LBE_W +: LBE_W]     = laneBe;
  end

  assign localAddr   = addrReg;
  assign localCmd    = cmdReg;
  assign localReq64  = req64Reg;
  assign localBarSel = barReg;

endmodule

// File: rtl/pciwr_ctrl.sv
module pciwr_ctrl
  import pciwr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pciFrameN,
  input  logic      pciIrdyN,
  input  logic      anyHit,
  input  logic      req64,
  input  logic      localRdyN,
  output dpStrobe_t strobe,
  output logic      devselN,
  output logic      ack64N,
  output logic      trdyN,
  output logic      stopN,
  output logic      ctlOe,
  output logic      adOe,
  output logic      parOe,
  output logic      localAckN,
  output logic      localXferN,
  output logic      localFrameN
);

  wrState_t state, stateNxt;
  logic     rdySeen;
  logic     phaseDone;
  logic     drvNxt;

  // bus control lines, decoded from state
  assign devselN   = ~(state == ST_DATA);
  assign ack64N    = ~((state == ST_DATA) && req64);
  assign trdyN     = ~((state == ST_DATA) && rdySeen);
  assign stopN     = 1'b1;
  assign adOe      = ctlOe;
  assign phaseDone = (state == ST_DATA) && !pciIrdyN && !trdyN;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (!pciFrameN) stateNxt = ST_DECODE;
      ST_DECODE: stateNxt = anyHit ? ST_CLAIM : ST_SKIP;
      ST_CLAIM:  stateNxt = ST_DATA;
      ST_DATA:   if (phaseDone && pciFrameN) stateNxt = ST_TURN;
      ST_TURN:   stateNxt = ST_IDLE;
      ST_SKIP:   if (pciFrameN && pciIrdyN) stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign drvNxt = (stateNxt == ST_CLAIM) || (stateNxt == ST_DATA) ||
                  (stateNxt == ST_TURN);

  always_comb begin
    strobe           = '0;
    strobe.latchAddr = (state == ST_IDLE) && !pciFrameN;
    strobe.claim     = (state == ST_DECODE) && anyHit;
    strobe.capture   = phaseDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      ctlOe       <= 1'b0;
      parOe       <= 1'b0;
      rdySeen     <= 1'b0;
      localAckN   <= 1'b1;
      localXferN  <= 1'b1;
      localFrameN <= 1'b1;
    end else begin
      state      <= stateNxt;
      ctlOe      <= drvNxt;
      parOe      <= drvNxt && ctlOe;
      localAckN  <= ~phaseDone;
      localXferN <= ~(phaseDone && !localRdyN);

      if (state == ST_IDLE) begin
        rdySeen <= 1'b0;
      end else if (((state == ST_CLAIM) || (state == ST_DATA)) && !localRdyN) begin
        rdySeen <= 1'b1;
      end

      if (strobe.claim) begin
        localFrameN <= 1'b0;
      end else if ((state == ST_IDLE) && localAckN) begin
        localFrameN <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pciwr_target.sv
module pciwr_target
  import pciwr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_BARS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pciFrameN,
  input  logic                 pciReq64N,
  input  logic                 pciIrdyN,
  input  logic [DATA_W-1:0]    pciAd,
  input  logic [DATA_W/8-1:0]  pciCbe,
  input  logic [NUM_BARS-1:0]  barHit,
  output logic                 devselN,
  output logic                 ack64N,
  output logic                 trdyN,
  output logic                 stopN,
  output logic                 ctlOe,
  output logic                 adOe,
  output logic                 parOe,
  output logic [DATA_W/2-1:0]  localAddr,
  output logic [DATA_W/16-1:0] localCmd,
  output logic                 localReq64,
  output logic [NUM_BARS-1:0]  localBarSel,
  output logic                 localFrameN,
  input  logic                 localRdyN,
  output logic                 localAckN,
  output logic                 localXferN,
  output logic [DATA_W-1:0]    localData,
  output logic [DATA_W/8-1:0]  localBe
);

  dpStrobe_t strobe;
  logic      anyHit;

  pciwr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pciFrameN  (pciFrameN),
    .pciIrdyN   (pciIrdyN),
    .anyHit     (anyHit),
    .req64      (localReq64),
    .localRdyN  (localRdyN),
    .strobe     (strobe),
    .devselN    (devselN),
    .ack64N     (ack64N),
    .trdyN      (trdyN),
    .stopN      (stopN),
    .ctlOe      (ctlOe),
    .adOe       (adOe),
    .parOe      (parOe),
    .localAckN  (localAckN),
    .localXferN (localXferN),
    .localFrameN(localFrameN)
  );

  pciwr_dpath #(
    .DATA_W  (DATA_W),
    .NUM_BARS(NUM_BARS)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pciAd      (pciAd),
    .pciCbe     (pciCbe),
    .pciReq64N  (pciReq64N),
    .barHit     (barHit),
    .anyHit     (anyHit),
    .localAddr  (localAddr),
    .localCmd   (localCmd),
    .localReq64 (localReq64),
    .localBarSel(localBarSel),
    .localData  (localData),
    .localBe    (localBe)
  );

endmodule

// File: rtl/pciwr_target_chk.sv
module pciwr_target_chk (
  input logic clk,
  input logic rstN,
  input logic pciIrdyN,
  input logic devselN,
  input logic ack64N,
  input logic trdyN,
  input logic ctlOe,
  input logic parOe,
  input logic localAckN,
  input logic localXferN
);

  // R5
  par_after_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlOe) |-> !parOe);

  // R5
  par_within_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> ctlOe);

  // R8
  xfer_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !localXferN |-> !localAckN);

  // R4
  devsel_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devselN |-> ctlOe);

  // R4
  ack64_with_devsel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ack64N |-> !devselN);

  // R7
  phase_to_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pciIrdyN && !trdyN) |=> !localAckN);

  // R9
  high_before_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlOe && $past(ctlOe)) |-> ($past(devselN) && $past(trdyN) && $past(ack64N)));

endmodule

bind pciwr_target pciwr_target_chk i_chk (.*);

// File: tb/test_pciwr_target.sv
`timescale 1ns/100ps
module test_pciwr_target;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pciFrameN = 1'b1, pciReq64N = 1'b1, pciIrdyN = 1'b1;
  logic [63:0] pciAd = '0;
  logic [7:0]  pciCbe = '0;
  logic [5:0]  barHit = '0;
  logic        localRdyN = 1'b1;
  logic        devselN, ack64N, trdyN, stopN, ctlOe, adOe, parOe;
  logic [31:0] localAddr;
  logic [3:0]  localCmd;
  logic        localReq64;
  logic [5:0]  localBarSel;
  logic        localFrameN, localAckN, localXferN;
  logic [63:0] localData;
  logic [7:0]  localBe;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pciwr_target i_pciwr_target (
    .clk(clk), .rstN(rstN), .pciFrameN(pciFrameN), .pciReq64N(pciReq64N),
    .pciIrdyN(pciIrdyN), .pciAd(pciAd), .pciCbe(pciCbe), .barHit(barHit),
    .devselN(devselN), .ack64N(ack64N), .trdyN(trdyN), .stopN(stopN),
    .ctlOe(ctlOe), .adOe(adOe), .parOe(parOe), .localAddr(localAddr),
    .localCmd(localCmd), .localReq64(localReq64), .localBarSel(localBarSel),
    .localFrameN(localFrameN), .localRdyN(localRdyN), .localAckN(localAckN),
    .localXferN(localXferN), .localData(localData), .localBe(localBe)
  );

  localparam logic [31:0] ADDR_A = 32'h8000_1230;
  localparam logic [31:0] ADDR_B = 32'h4000_0ab8;

  function automatic logic [63:0] datOf(int i);
    return {32'hc0de_0000 + 32'(i), 32'h5a00_0000 + 32'(i)};
  endfunction

  function automatic logic [7:0] beOf(int i);
    return 8'hf0 ^ 8'(i);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // burst table: one row per clock
  typedef struct packed {
    logic       fr, ir, rdy, isAddr;
    logic [2:0] dIdx;
    logic       eDev, eTrdy, eAck64, eOe, eLack, eLx, eLfr;
    logic [2:0] eIdx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0,3'd0, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,3'd0},
    '{1'b0,1'b1,1'b1,1'b1,3'd0, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,3'd0},
    '{1'b0,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,3'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,3'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,3'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0},
    '{1'b0,1'b1,1'b0,1'b0,3'd2, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd1},
    '{1'b0,1'b0,1'b1,1'b0,3'd2, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,3'd0},
    '{1'b1,1'b0,1'b0,1'b0,3'd3, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,3'd2},
    '{1'b1,1'b1,1'b0,1'b0,3'd3, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,3'd3},
    '{1'b1,1'b1,1'b1,1'b0,3'd0, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,3'd0},
    '{1'b1,1'b1,1'b1,1'b0,3'd0, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,3'd0}
  };

  task automatic idleBus();
    pciFrameN = 1'b1; pciReq64N = 1'b1; pciIrdyN = 1'b1; localRdyN = 1'b1;
  endtask

  task automatic addrPhase(logic [31:0] a, logic [3:0] cmd, logic r64);
    pciFrameN = 1'b0; pciReq64N = ~r64; pciIrdyN = 1'b1;
    pciAd = {32'h0, a}; pciCbe = {4'h0, cmd};
  endtask

  task automatic dataPhase(logic fr, logic ir, int i);
    pciFrameN = fr; pciReq64N = 1'b1; pciIrdyN = ir;
    pciAd = datOf(i); pciCbe = beOf(i);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    // reset
    repeat (3) @(negedge clk);
    chk("R1", "ctlOe in reset", ctlOe, 0);
    chk("R1", "parOe in reset", parOe, 0);
    chk("R1", "localFrameN in reset", localFrameN, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "adOe after reset", adOe, 0);
    chk("R1", "devselN/trdyN/ack64N/stopN", {devselN, trdyN, ack64N, stopN}, 4'hf);
    chk("R1", "localAckN/localXferN", {localAckN, localXferN}, 2'b11);

    // burst table, hit on window 1, 64-bit request
    barHit = 6'b000010;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk("R4", $sformatf("row%0d devselN", i), devselN, VECS[i].eDev);
      chk("R6", $sformatf("row%0d trdyN", i), trdyN, VECS[i].eTrdy);
      chk("R4", $sformatf("row%0d ack64N", i), ack64N, VECS[i].eAck64);
      chk("R3", $sformatf("row%0d ctlOe", i), ctlOe, VECS[i].eOe);
      chk("R7", $sformatf("row%0d localAckN", i), localAckN, VECS[i].eLack);
      chk("R8", $sformatf("row%0d localXferN", i), localXferN, VECS[i].eLx);
      chk("R10", $sformatf("row%0d localFrameN", i), localFrameN, VECS[i].eLfr);
      if (!VECS[i].eLack) begin
        chk("R7", $sformatf("row%0d localData", i), localData, datOf(VECS[i].eIdx));
        chk("R7", $sformatf("row%0d localBe", i), localBe, beOf(VECS[i].eIdx));
      end
      if (VECS[i].isAddr) addrPhase(ADDR_A, 4'h7, 1'b1);
      else dataPhase(VECS[i].fr, VECS[i].ir, VECS[i].dIdx);
      localRdyN = VECS[i].rdy;
    end

    // single 32-bit write, late local ready, hit on window 2
    @(negedge clk); barHit = 6'b000100; addrPhase(ADDR_B, 4'h6, 1'b0);
    @(negedge clk); dataPhase(1'b1, 1'b0, 5);
    @(negedge clk);  // claim clock
    chk("R3", "adOe at claim", adOe, 1);
    chk("R5", "parOe at claim", parOe, 0);
    chk("R2", "localAddr", localAddr, ADDR_B);
    chk("R2", "localCmd", localCmd, 4'h6);
    chk("R2", "localReq64 for 32-bit", localReq64, 0);
    chk("R2", "localBarSel", localBarSel, 6'b000100);
    chk("R3", "localFrameN at claim", localFrameN, 0);
    @(negedge clk);
    chk("R4", "devselN first data clock", devselN, 0);
    chk("R4", "ack64N held for 32-bit", ack64N, 1);
    chk("R5", "parOe one clock later", parOe, 1);
    chk("R6", "trdyN held, no ready", trdyN, 1);
    @(negedge clk);
    chk("R6", "trdyN still held", trdyN, 1);
    @(negedge clk);
    chk("R6", "trdyN held before ready", trdyN, 1);
    localRdyN = 1'b0;
    @(negedge clk);
    chk("R6", "trdyN after late ready", trdyN, 0);
    chk("R4", "stopN high", stopN, 1);
    @(negedge clk);  // turnaround
    localRdyN = 1'b1;
    chk("R9", "controls high in turnaround", {devselN, trdyN, ack64N, stopN}, 4'hf);
    chk("R9", "ctlOe in turnaround", ctlOe, 1);
    chk("R7", "single localAckN", localAckN, 0);
    chk("R7", "single localData", localData, datOf(5));
    chk("R8", "single localXferN", localXferN, 0);
    idleBus();
    @(negedge clk);
    chk("R9", "enables off", {ctlOe, adOe, parOe}, 3'b000);
    chk("R10", "localFrameN still low", localFrameN, 0);
    @(negedge clk);
    chk("R10", "localFrameN released", localFrameN, 1);

    // missed decode with a stray frame-low clock, then a normal claim
    @(negedge clk); barHit = 6'b000000; addrPhase(ADDR_A, 4'h7, 1'b1);
    @(negedge clk); dataPhase(1'b0, 1'b0, 1);
    @(negedge clk); barHit = 6'b000001; dataPhase(1'b0, 1'b1, 1);
    chk("R11", "miss ctlOe", ctlOe, 0);
    @(negedge clk); dataPhase(1'b0, 1'b0, 2);
    chk("R11", "miss localFrameN", localFrameN, 1);
    @(negedge clk); dataPhase(1'b1, 1'b0, 3);
    chk("R11", "miss no claim a", ctlOe, 0);
    @(negedge clk); idleBus();
    chk("R11", "miss no claim b", ctlOe, 0);
    chk("R11", "miss localAckN", localAckN, 1);
    @(negedge clk); barHit = 6'b100000; addrPhase(ADDR_A, 4'h7, 1'b1);
    chk("R11", "miss no claim c", {ctlOe, devselN}, 2'b01);
    @(negedge clk); dataPhase(1'b1, 1'b0, 4); localRdyN = 1'b0;
    @(negedge clk);
    chk("R11", "claim after miss", ctlOe, 1);
    chk("R2", "localBarSel after miss", localBarSel, 6'b100000);
    @(negedge clk);
    chk("R12", "trdyN with early ready", trdyN, 0);
    chk("R4", "ack64N for 64-bit", ack64N, 0);
    @(negedge clk); idleBus();
    chk("R7", "final data after miss", localData, datOf(4));
    repeat (3) @(negedge clk);
    chk("R10", "idle localFrameN", localFrameN, 1);

    summary();
    $finish;
  end

endmodule